// File: doc/BRIEF.md
# Edge-Interval Speed Classifier

This block measures how many reference ticks elapse between two successive events on a sensor line. It then sorts that interval into overlapping speed bands. Both the tick line and the sensor line are asynchronous single-bit inputs. Each one passes through a synchronizer and is watched for high-to-low transitions.

Every falling tick edge adds one to an internal session count. Every falling sensor edge does two things. It grades the session count onto a registered 4-bit status port, and it clears the count so that a fresh session starts.

The status port is a plain set of levels, not a data stream. It has no valid/ready handshake and exerts no back-pressure. Each bit holds its value until the next sensor event rewrites all four bits. A typical use is a supervisor that checks a machine's event rate and raises "too fast", "okay", "getting slow" and "slow" flags.

Top module: `interval_grader`

## Requirements
- R1: While `rst` is high at a rising clock edge, the status port is cleared to 4'b0000 on that edge, and the session count returns to zero.
- R2: Each high-to-low transition of `tick_in` raises the session count by one.
- R3: Low-to-high transitions of `tick_in` do not change the count. A tick pulse (high, then low, then high) adds exactly one.
- R4: On a sensor event with a graded count below 100, status bit 0 (too fast) is set and no other bit is set.
- R5: On a sensor event with a graded count from 100 through 255, status bit 1 (okay) is set.
- R6: On a sensor event with a graded count from 201 through 255, status bit 2 (getting slow) is set along with bit 1. From 100 through 200, bit 2 is clear.
- R7: On a sensor event with a graded count above 255, status bit 3 (slow) is set and bit 2 is forced clear. Bits 0 and 1 are also clear.
- R8: A sensor event clears the session count. The next event grades only the ticks that arrive after it.
- R9: The count saturates at its largest value (2^CNT_W-1) instead of wrapping. A long session is therefore still graded as slow.
- R10: When a tick edge and a sensor edge are detected in the same cycle, the tick is included in the graded value and is not carried into the next session.
- R11: Between sensor events the status port holds its value, whatever the tick activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; synchronizer stages reset to the idle-high level |
| tick_in | input | 1 | Asynchronous reference tick line; falling edges are counted |
| sense_in | input | 1 | Asynchronous sensor line; falling edges grade and restart the session |
| status_o | output | 4 | Band flags: bit0 too fast, bit1 okay, bit2 getting slow, bit3 slow |

## Verification
Some properties are checked on every cycle. The band flags stay consistent: at most one of too fast, okay and slow is set, getting slow implies okay, and slow excludes getting slow. The status holds when there is no sensor event, and the count is zero right after one. The count steps by one on a lone tick edge and stays put at saturation. Only the bench's scenarios can show that the band boundaries fall at exactly 99/100, 200/201 and 255/256, and that rising tick edges are ignored. They also show that a coincident tick lands in the graded session and not in the next one, and that saturation keeps an over-long session graded slow where a wrapping counter would report too fast.

// File: rtl/igr_pkg.sv
package igr_pkg;
  localparam int STATUS_W  = 4;
  localparam int FAST_LIM  = 100;  // below this: too fast
  localparam int OK_MAX    = 255;  // okay band upper bound
  localparam int WARN_MIN  = 201;  // getting-slow band lower bound

  typedef struct packed {
    logic slow;
    logic warn;
    logic ok;
    logic fast;
  } status_t;
endpackage

// File: rtl/igr_fall_detect.sv
module igr_fall_detect #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic fall_o
);
  // chain[0..STAGES-1] synchronizer, chain[STAGES] previous synced sample
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES+1){IDLE}};
    else     chain <= {chain[STAGES-1:0], async_i};
  end

  assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/igr_tick_counter.sv
module igr_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    next_o = count_o;
    if (inc_i && count_o != CNT_MAX) next_o = count_o + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) count_o <= '0;
    else                count_o <= next_o;
  end
endmodule

// File: rtl/igr_grader.sv
module igr_grader
  import igr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] count_i,
  output status_t          status_o
);
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(FAST_LIM);
  localparam logic [CNT_W-1:0] LIM_OK   = CNT_W'(OK_MAX);
  localparam logic [CNT_W-1:0] LIM_WARN = CNT_W'(WARN_MIN);

  status_t grade;

  always_comb begin
    grade.fast = count_i < LIM_FAST;
    grade.ok   = (count_i >= LIM_FAST) && (count_i <= LIM_OK);
    grade.warn = (count_i >= LIM_WARN) && (count_i <= LIM_OK);
    grade.slow = count_i > LIM_OK;
  end

  always_ff @(posedge clk) begin
    if (rst)         status_o <= '0;
    else if (eval_i) status_o <= grade;
  end
endmodule

// File: rtl/interval_grader.sv
module interval_grader
  import igr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_in,
  input  logic                sense_in,
  output logic [STATUS_W-1:0] status_o
);
  localparam int N_IN = 2;  // 0: tick, 1: sense

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] fall;
  logic            tick_fall;
  logic            sense_fall;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  status_t          status_q;

  assign raw_in = {sense_in, tick_in};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    igr_fall_detect #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) det_i (
      .clk(clk), .rst(rst), .async_i(raw_in[g]), .fall_o(fall[g])
    );
  end

  assign tick_fall  = fall[0];
  assign sense_fall = fall[1];

  igr_tick_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .inc_i(tick_fall), .clear_i(sense_fall),
    .count_o(count_q), .next_o(count_d)
  );

  igr_grader #(.CNT_W(CNT_W)) grd_i (
    .clk(clk), .rst(rst), .eval_i(sense_fall), .count_i(count_d),
    .status_o(status_q)
  );

  assign status_o = status_q;
endmodule

// File: rtl/igr_checker.sv
module igr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_fall,
  input logic             sense_fall,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       status
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> status == 4'b0000); // R1
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_fall && !sense_fall && count != CMAX) |=> count == $past(count) + CNT_W'(1)); // R2
  AST_BANDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status[3], status[1], status[0]})); // R4
  AST_WARN_IN_OK: assert property (@(posedge clk) disable iff (rst)
    status[2] |-> status[1]); // R6
  AST_SLOW_NO_WARN: assert property (@(posedge clk) disable iff (rst)
    status[3] |-> !status[2]); // R7
  AST_SESSION_RESTART: assert property (@(posedge clk) disable iff (rst)
    sense_fall |=> count == '0); // R8
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && !sense_fall) |=> count == CMAX); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sense_fall |=> $stable(status)); // R11
endmodule

bind interval_grader igr_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick_fall(tick_fall), .sense_fall(sense_fall),
  .count(count_q), .status(status_o)
);

// File: tb/interval_grader_tb_top.sv
module interval_grader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b1;
  logic sense_in = 1'b1;
  logic [3:0] status_o;
  logic [3:0] status_sat;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  interval_grader dut_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .sense_in(sense_in), .status_o(status_o)
  );

  // narrow counter (max 511) to make saturation reachable
  interval_grader #(.CNT_W(9)) dut_sat_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .sense_in(sense_in), .status_o(status_sat)
  );

  localparam int NV = 9;
  localparam int VEC_TICKS [NV] = '{50, 99, 100, 200, 201, 255, 256, 400, 0};
  localparam logic [3:0] VEC_EXP [NV] =
    '{4'b0001, 4'b0001, 4'b0010, 4'b0010, 4'b0110, 4'b0110, 4'b1000, 4'b1000, 4'b0001};
  localparam string VEC_REQ [NV] = '{"R4/R2", "R4/R3", "R5", "R6", "R6", "R6", "R7", "R7", "R4/R8"};

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b0; wait_n(3);
      tick_in = 1'b1; wait_n(3);
    end
  endtask

  task automatic sense_pulse(input bit with_tick);
    sense_in = 1'b0;
    if (with_tick) tick_in = 1'b0;
    wait_n(3);
    sense_in = 1'b1;
    tick_in = 1'b1;
    wait_n(4);
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: status=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    wait_n(4);
    check("R1", status_o, 4'b0000);
    check("R1", status_sat, 4'b0000);
    rst = 1'b0;
    wait_n(2);

    for (int v = 0; v < NV; v++) begin
      ticks(VEC_TICKS[v]);
      sense_pulse(1'b0);
      check(VEC_REQ[v], status_o, VEC_EXP[v]);
    end

    // R11: ticks with no sensor event leave status untouched
    ticks(300);
    check("R11", status_o, 4'b0001);
    sense_pulse(1'b0);
    check("R7", status_o, 4'b1000);

    // R10: 99 ticks + coincident tick/sense -> graded 100 (okay)
    ticks(99);
    sense_pulse(1'b1);
    check("R10", status_o, 4'b0010);
    // R10/R8: coincident tick not carried -> 99 grades too fast
    ticks(99);
    sense_pulse(1'b0);
    check("R10", status_o, 4'b0001);

    // R9: 600 ticks on 9-bit counter stay saturated -> slow, not wrapped
    ticks(600);
    sense_pulse(1'b0);
    check("R9", status_sat, 4'b1000);
    check("R9", status_o, 4'b1000);

    // R1: reset mid-operation clears status
    rst = 1'b1; wait_n(2);
    check("R1", status_o, 4'b0000);
    rst = 1'b0; wait_n(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule